// File: doc/BRIEF.md
# I2C Slave Interface with Bus Status Flags

This block is the target side of a two-wire serial bus. It watches the clock line (SCL) and the data line (SDA), both already synchronised to the system clock. It detects start and stop conditions and compares the first byte or bytes after a start with an address the host has loaded. Once the address matches, it accepts data bytes into a one-byte buffer or sends them from that buffer. The block drives SDA only by pulling it low, through `sda_pull_o`, and pulls it low only to acknowledge a byte or to send a zero bit.

The host side has five parts:
- an enable input;
- a 7-bit / 10-bit mode select;
- an address register that can be written at any time;
- a buffer write port and a buffer read port;
- six status flags: last condition was a start, last condition was a stop, transfer direction, address update needed, buffer full, and overflow.

The flags have defined lifetimes. The direction flag is only meaningful from an address match until the next start, stop or refused byte. In 10-bit mode the update flag asks the host to put the low address byte into the address register before the second address byte arrives. In transmit, the buffer-full flag covers only the eight data bits and not the acknowledge clock.

The controller is a single state machine with seven states:
- `ST_IDLE`: ignore the bus.
- `ST_ADDR`: shift in an address byte.
- `ST_AACK`: acknowledge the address.
- `ST_RX`: shift in a data byte.
- `ST_DACK`: acknowledge or refuse a received byte.
- `ST_TX`: shift out a data byte.
- `ST_TACK`: sample the master's acknowledge.

Its transitions are:
- From any state:
  - a disabled block goes to `ST_IDLE`;
  - a start goes to `ST_ADDR`;
  - a stop goes to `ST_IDLE`.
- `ST_ADDR` → `ST_AACK` on a matching eighth bit, or `ST_ADDR` → `ST_IDLE` on a miss.
- `ST_AACK` → `ST_ADDR` when a second 10-bit byte is due. Otherwise it goes to `ST_TX` for a read or `ST_RX` for a write, at the falling edge that ends the acknowledge clock.
- `ST_RX` → `ST_DACK` after eight bits.
- `ST_DACK` → `ST_RX` after an acknowledged byte, or `ST_DACK` → `ST_IDLE` after a refused one.
- `ST_TX` → `ST_TACK` after eight falling edges.
- `ST_TACK` → `ST_TX` on a master acknowledge, or `ST_TACK` → `ST_IDLE` on a master not-acknowledge.

Top module: `i2c_slave_stat`

## Requirements
- R1: After reset all six status flags are 0 and `sda_pull_o` is 0.
- R2: A start (SDA falls while SCL is high) sets the start flag and clears the stop flag. A stop (SDA rises while SCL is high) sets the stop flag and clears the start flag. The two flags are never 1 together.
- R3: While `en_i` is 0, the start flag is forced to 0, the controller returns to idle and SDA is released.
- R4: In 7-bit mode, bits 7..1 of the first byte after a start (sent MSB first) are compared with bits 6..0 of the address register.
  - On a match the block pulls SDA low for the ninth clock.
  - On a miss it does not acknowledge, and it ignores all further bytes until the next start.
- R5: On a completed address match the direction flag takes bit 0 of the address byte (1 = read, 0 = write). A start, a stop or a not-acknowledged byte clears it.
- R6: In 10-bit mode the first byte must be 11110, then bits 1..0 of the address register, then the R/W bit.
  - On a match that byte is acknowledged and the update flag is set.
  - A host write to the address register clears the update flag.
  - The second byte must equal all eight bits of the address register.
  - The direction is taken from bit 0 of the first byte.
- R7: In a write transfer, a byte that completes while the buffer is empty is acknowledged, appears on `buf_rdata_o` and sets the buffer-full flag. A `buf_rd_i` pulse clears the flag.
- R8: A byte that completes while the buffer-full flag is 1 sets the overflow flag and is not acknowledged. The buffer keeps its earlier contents and the direction flag is cleared. A `buf_rd_i` pulse clears the overflow flag.
- R9: In a read transfer, `buf_wr_i` loads the buffer and sets the buffer-full flag. The byte is sent MSB first, with a new bit after each SCL falling edge, starting at the edge that ends the address acknowledge. The buffer-full flag drops at the falling edge that ends the eighth data bit, before the acknowledge clock.
- R10: In a read transfer:
  - a master acknowledge starts the next byte from the buffer;
  - a master not-acknowledge clears the direction flag and leaves SDA released until the next start.
- R11: While enabled, `sda_pull_o` changes only while SCL is low, so an acknowledge is held steady through the whole SCL high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 8 | Address register write data |
| buf_wr_i | input | 1 | Buffer write strobe |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rd_i | input | 1 | Buffer read strobe (clears full and overflow) |
| buf_rdata_o | output | 8 | Buffer contents |
| st_start_o | output | 1 | Last bus condition was a start |
| st_stop_o | output | 1 | Last bus condition was a stop |
| st_rw_o | output | 1 | Direction of the current transfer (1 = read) |
| st_ua_o | output | 1 | Host must load the next address part |
| st_bf_o | output | 1 | Buffer full |
| st_ovf_o | output | 1 | Byte received while buffer full |

## Verification
The bench sweeps every 7-bit address and every 10-bit high-bit pair against a fixed own address. A comparator off by one bit, or shifting LSB first, would acknowledge the wrong addresses or respond to bytes after a miss. It receives all 256 data values and reads back a range of transmit patterns. It checks that buffer-full drops before the acknowledge clock: a design that waits for the acknowledge would report a full buffer there. Further sequences cover a byte arriving into a full buffer, a repeated start and a stop in the middle of a read, and disabling the block after a start. A design that keeps a stale direction bit or leaves the start flag set would miscompare on these.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;
    localparam int PFX_W  = 5;
    localparam logic [PFX_W-1:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_DACK,
        ST_TX,
        ST_TACK
    } ctrl_state_e;

endpackage

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_q & scl_i & sda_q & ~sda_i;
        stop_o     = scl_q & scl_i & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2cs_addr_cmp.sv
module i2cs_addr_cmp
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] own_i,
    input  logic              ten_bit_i,
    input  logic              hi_done_i,
    output logic              hit_o,
    output logic              hi_hit_o
);

    localparam int HI_W = BYTE_W - PFX_W - 1;

    logic seven_hit;
    logic hi_form_hit;
    logic low_hit;

    always_comb begin
        seven_hit   = (byte_i[BYTE_W-1:1] == own_i[BYTE_W-2:0]);
        hi_form_hit = (byte_i[BYTE_W-1:BYTE_W-PFX_W] == TEN_PREFIX) &&
                      (byte_i[HI_W:1] == own_i[HI_W-1:0]);
        low_hit     = (byte_i == own_i);

        hit_o    = 1'b0;
        hi_hit_o = 1'b0;
        if (!ten_bit_i) begin
            hit_o = seven_hit;
        end else if (!hi_done_i) begin
            hi_hit_o = hi_form_hit;
            hit_o    = hi_form_hit;
        end else begin
            hit_o = low_hit;
        end
    end

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ten_bit_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] own_addr_i,
    input  logic              addr_wr_i,
    input  logic              buf_wr_i,
    input  logic [BYTE_W-1:0] buf_wdata_i,
    input  logic              buf_rd_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] buf_q_o,
    output logic              start_f_o,
    output logic              stop_f_o,
    output logic              rw_f_o,
    output logic              ua_f_o,
    output logic              bf_f_o,
    output logic              ovf_f_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    ctrl_state_e state;
    ctrl_state_e nxt;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sr_q;
    logic [BYTE_W-1:0] tx_sr_q;
    logic [BYTE_W-1:0] rx_byte_n;
    logic              ph_q;
    logic              ack_q;
    logic              hi_done_q;
    logic              more_addr_q;
    logic              rw_pend_q;
    logic              nack_q;
    logic              addr_hit;
    logic              addr_hi_hit;
    logic              last_bit;

    assign rx_byte_n = {sr_q[BYTE_W-2:0], sda_i};
    assign last_bit  = (cnt_q == LAST_BIT);

    i2cs_addr_cmp u_cmp (
        .byte_i    (rx_byte_n),
        .own_i     (own_addr_i),
        .ten_bit_i (ten_bit_i),
        .hi_done_i (hi_done_q),
        .hit_o     (addr_hit),
        .hi_hit_o  (addr_hi_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!en_i) begin
            nxt = ST_IDLE;
        end else if (start_i) begin
            nxt = ST_ADDR;
        end else if (stop_i) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (scl_rise_i && last_bit) nxt = addr_hit ? ST_AACK : ST_IDLE;
                ST_AACK: if (scl_fall_i && ph_q)
                             nxt = more_addr_q ? ST_ADDR : (rw_f_o ? ST_TX : ST_RX);
                ST_RX:   if (scl_rise_i && last_bit) nxt = ST_DACK;
                ST_DACK: if (scl_fall_i && ph_q) nxt = ack_q ? ST_RX : ST_IDLE;
                ST_TX:   if (scl_fall_i && last_bit) nxt = ST_TACK;
                ST_TACK: if (scl_fall_i) nxt = nack_q ? ST_IDLE : ST_TX;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            sr_q        <= '0;
            tx_sr_q     <= '0;
            ph_q        <= 1'b0;
            ack_q       <= 1'b0;
            hi_done_q   <= 1'b0;
            more_addr_q <= 1'b0;
            rw_pend_q   <= 1'b0;
            nack_q      <= 1'b0;
            buf_q_o     <= '0;
            start_f_o   <= 1'b0;
            stop_f_o    <= 1'b0;
            rw_f_o      <= 1'b0;
            ua_f_o      <= 1'b0;
            bf_f_o      <= 1'b0;
            ovf_f_o     <= 1'b0;
        end else begin
            if (addr_wr_i) ua_f_o <= 1'b0;
            if (buf_wr_i) begin
                buf_q_o <= buf_wdata_i;
                bf_f_o  <= 1'b1;
            end
            if (buf_rd_i) begin
                bf_f_o  <= 1'b0;
                ovf_f_o <= 1'b0;
            end

            if (!en_i) begin
                start_f_o <= 1'b0;
                stop_f_o  <= 1'b0;
                rw_f_o    <= 1'b0;
                ua_f_o    <= 1'b0;
                ph_q      <= 1'b0;
                cnt_q     <= '0;
                hi_done_q <= 1'b0;
            end else if (start_i) begin
                start_f_o <= 1'b1;
                stop_f_o  <= 1'b0;
                rw_f_o    <= 1'b0;
                cnt_q     <= '0;
                ph_q      <= 1'b0;
                hi_done_q <= 1'b0;
            end else if (stop_i) begin
                stop_f_o  <= 1'b1;
                start_f_o <= 1'b0;
                rw_f_o    <= 1'b0;
                hi_done_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (scl_rise_i) begin
                        sr_q  <= rx_byte_n;
                        cnt_q <= cnt_q + 1'b1;
                        if (last_bit) begin
                            cnt_q <= '0;
                            ph_q  <= 1'b0;
                            ack_q <= 1'b1;
                            if (addr_hi_hit) begin
                                ua_f_o      <= 1'b1;
                                rw_pend_q   <= rx_byte_n[0];
                                hi_done_q   <= 1'b1;
                                more_addr_q <= 1'b1;
                            end else if (addr_hit) begin
                                more_addr_q <= 1'b0;
                                rw_f_o      <= ten_bit_i ? rw_pend_q : rx_byte_n[0];
                            end
                        end
                    end
                    ST_AACK: if (scl_fall_i) begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            ph_q    <= 1'b0;
                            cnt_q   <= '0;
                            tx_sr_q <= buf_q_o;
                        end
                    end
                    ST_RX: if (scl_rise_i) begin
                        sr_q  <= rx_byte_n;
                        cnt_q <= cnt_q + 1'b1;
                        if (last_bit) begin
                            cnt_q <= '0;
                            ph_q  <= 1'b0;
                            if (bf_f_o) begin
                                ovf_f_o <= 1'b1;
                                ack_q   <= 1'b0;
                            end else begin
                                buf_q_o <= rx_byte_n;
                                bf_f_o  <= 1'b1;
                                ack_q   <= 1'b1;
                            end
                        end
                    end
                    ST_DACK: if (scl_fall_i) begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            ph_q <= 1'b0;
                            if (!ack_q) rw_f_o <= 1'b0;
                        end
                    end
                    ST_TX: if (scl_fall_i) begin
                        tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                        if (last_bit) begin
                            cnt_q  <= '0;
                            bf_f_o <= 1'b0;
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise_i) nack_q <= sda_i;
                        if (scl_fall_i) begin
                            tx_sr_q <= buf_q_o;
                            if (nack_q) rw_f_o <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state)
            ST_AACK, ST_DACK: sda_pull_o = ph_q & ack_q;
            ST_TX:            sda_pull_o = ~tx_sr_q[BYTE_W-1];
            default:          sda_pull_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_slave_stat.sv
module i2c_slave_stat
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ten_bit_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              addr_wr_i,
    input  logic [BYTE_W-1:0] addr_wdata_i,
    input  logic              buf_wr_i,
    input  logic [BYTE_W-1:0] buf_wdata_i,
    input  logic              buf_rd_i,
    output logic [BYTE_W-1:0] buf_rdata_o,
    output logic              st_start_o,
    output logic              st_stop_o,
    output logic              st_rw_o,
    output logic              st_ua_o,
    output logic              st_bf_o,
    output logic              st_ovf_o
);

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] own_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         own_addr_q <= '0;
        else if (addr_wr_i) own_addr_q <= addr_wdata_i;
    end

    i2cs_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2cs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .ten_bit_i   (ten_bit_i),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_i       (sda_i),
        .own_addr_i  (own_addr_q),
        .addr_wr_i   (addr_wr_i),
        .buf_wr_i    (buf_wr_i),
        .buf_wdata_i (buf_wdata_i),
        .buf_rd_i    (buf_rd_i),
        .sda_pull_o  (sda_pull_o),
        .buf_q_o     (buf_rdata_o),
        .start_f_o   (st_start_o),
        .stop_f_o    (st_stop_o),
        .rw_f_o      (st_rw_o),
        .ua_f_o      (st_ua_o),
        .bf_f_o      (st_bf_o),
        .ovf_f_o     (st_ovf_o)
    );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic ten_bit_i,
    input logic scl_i,
    input logic sda_pull_o,
    input logic st_start_o,
    input logic st_stop_o,
    input logic st_rw_o,
    input logic st_ua_o,
    input logic st_bf_o,
    input logic st_ovf_o
);

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_start_o && st_stop_o));

    // R3
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!st_start_o && !sda_pull_o));

    // R5
    start_fresh_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_start_o) |-> !st_rw_o);

    // R5
    stop_fresh_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_stop_o) |-> !st_rw_o);

    // R6
    ua_only_ten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ua_o) |-> ten_bit_i);

    // R8
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovf_o) |-> $past(st_bf_o));

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && (sda_pull_o != $past(sda_pull_o))) |-> !scl_i);

endmodule

bind i2c_slave_stat i2cs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .ten_bit_i  (ten_bit_i),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .st_start_o (st_start_o),
    .st_stop_o  (st_stop_o),
    .st_rw_o    (st_rw_o),
    .st_ua_o    (st_ua_o),
    .st_bf_o    (st_bf_o),
    .st_ovf_o   (st_ovf_o)
);

// File: tb/test_i2c_slave_stat.sv
module test_i2c_slave_stat;

    localparam int H   = 5;
    localparam int OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       ten = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       pull;
    logic       addr_wr = 1'b0;
    logic [7:0] addr_wd = 8'h00;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wd = 8'h00;
    logic       buf_rd = 1'b0;
    logic [7:0] rdata;
    logic       f_start, f_stop, f_rw, f_ua, f_bf, f_ovf;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~pull;

    i2c_slave_stat i_i2c_slave_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .ten_bit_i    (ten),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull_o   (pull),
        .addr_wr_i    (addr_wr),
        .addr_wdata_i (addr_wd),
        .buf_wr_i     (buf_wr),
        .buf_wdata_i  (buf_wd),
        .buf_rd_i     (buf_rd),
        .buf_rdata_o  (rdata),
        .st_start_o   (f_start),
        .st_stop_o    (f_stop),
        .st_rw_o      (f_rw),
        .st_ua_o      (f_ua),
        .st_bf_o      (f_bf),
        .st_ovf_o     (f_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bstop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; half();
        scl_m = 1'b1; half();
        s = sda_line;
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic held);
        logic s;
        logic e;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        sda_m = 1'b1; half();
        e = sda_line;
        scl_m = 1'b1; half();
        s = sda_line;
        scl_m = 1'b0;
        ack  = ~s;
        held = (e == s);
    endtask

    task automatic recv_bits(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
    endtask

    task automatic host_addr(input logic [7:0] v);
        @(negedge clk); addr_wd = v; addr_wr = 1'b1;
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); buf_wd = v; buf_wr = 1'b1;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic ack;
        logic held;
        logic s;
        logic [7:0] rb;
        logic [7:0] v0;
        logic [7:0] v1;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        chk("R1 flags", {26'd0, f_start, f_stop, f_rw, f_ua, f_bf, f_ovf}, 32'd0);
        chk("R1 pull", pull, 0);

        host_addr(8'(OWN));

        // R2 R4 R11: sweep of all 7-bit addresses
        for (int a = 0; a < 128; a++) begin
            bstart();
            chk("R2 start set", {f_start, f_stop}, 2'b10);
            send_byte({a[6:0], 1'b0}, ack, held);
            chk("R4 addr ack", ack, (a == OWN));
            settle();
            if (a == OWN) begin
                chk("R11 ack held", held, 1);
                chk("R5 rw write", f_rw, 0);
            end else begin
                send_byte(8'(a) ^ 8'hA5, ack, held);
                settle();
                chk("R4 ignored ack", ack, 0);
                chk("R4 ignored bf", f_bf, 0);
            end
            bstop();
            settle();
            chk("R2 stop set", {f_start, f_stop}, 2'b01);
        end

        // R7 sweep of all data values
        bstart();
        send_byte({7'(OWN), 1'b0}, ack, held);
        for (int d = 0; d < 256; d++) begin
            send_byte(8'(d), ack, held);
            settle();
            chk("R7 data ack", ack, 1);
            chk("R7 bf set", f_bf, 1);
            chk("R7 rdata", rdata, 32'(d));
            host_read();
            chk("R7 bf clear", f_bf, 0);
        end
        bstop();
        settle();

        // R8 overflow
        bstart();
        send_byte({7'(OWN), 1'b0}, ack, held);
        send_byte(8'h11, ack, held);
        chk("R8 first ack", ack, 1);
        send_byte(8'h22, ack, held);
        settle();
        chk("R8 second nack", ack, 0);
        chk("R8 ovf", f_ovf, 1);
        chk("R8 kept", rdata, 32'h11);
        chk("R8 rw cleared", f_rw, 0);
        host_read();
        chk("R8 ovf clear", {f_ovf, f_bf}, 2'b00);
        bstop();
        settle();

        // R9 R10 read transfers
        for (int k = 0; k < 16; k++) begin
            v0 = 8'(k * 37) ^ 8'h3C;
            v1 = ~8'(k * 11);
            host_write(v0);
            chk("R9 bf loaded", f_bf, 1);
            bstart();
            send_byte({7'(OWN), 1'b1}, ack, held);
            settle();
            chk("R5 rw read", f_rw, 1);
            recv_bits(rb);
            settle();
            chk("R9 bf drops before ack", f_bf, 0);
            chk("R9 byte0", rb, 32'(v0));
            host_write(v1);
            clock_bit(1'b0, s);
            recv_bits(rb);
            chk("R10 byte1", rb, 32'(v1));
            clock_bit(1'b1, s);
            settle();
            chk("R10 rw cleared", f_rw, 0);
            chk("R10 released", pull, 0);
            bstop();
            settle();
        end

        // R5 repeated start and stop mid-read
        host_write(8'hFF);
        bstart();
        send_byte({7'(OWN), 1'b1}, ack, held);
        settle();
        chk("R5 rw before restart", f_rw, 1);
        bstart();
        settle();
        chk("R5 rw after restart", {f_rw, f_start}, 2'b01);
        bstop();
        settle();
        bstart();
        send_byte({7'(OWN), 1'b1}, ack, held);
        bstop();
        settle();
        chk("R5 rw after stop", {f_rw, f_stop}, 2'b01);

        // R3 enable drop
        bstart();
        settle();
        chk("R3 start before", f_start, 1);
        @(negedge clk); en = 1'b0;
        settle();
        chk("R3 start forced", {f_start, pull}, 2'b00);
        @(negedge clk); en = 1'b1;
        bstop();
        settle();

        // R6 10-bit addressing sweep of high bits
        @(negedge clk); ten = 1'b1;
        host_read();
        for (int h = 0; h < 4; h++) begin
            host_addr(8'h02);
            bstart();
            send_byte({5'b11110, h[1:0], 1'b0}, ack, held);
            settle();
            chk("R6 first ack", ack, (h == 2));
            chk("R6 ua", f_ua, (h == 2));
            if (h == 2) begin
                host_addr(8'h37);
                chk("R6 ua cleared", f_ua, 0);
                send_byte(8'h37, ack, held);
                settle();
                chk("R6 second ack", ack, 1);
                chk("R6 rw", f_rw, 0);
                send_byte(8'h9C, ack, held);
                settle();
                chk("R6 data", {ack, f_bf, rdata}, {2'b11, 8'h9C});
                host_read();
            end
            bstop();
            settle();
        end
        host_addr(8'h02);
        bstart();
        send_byte(8'b11110_10_0, ack, held);
        host_addr(8'h37);
        send_byte(8'h38, ack, held);
        settle();
        chk("R6 wrong low nack", ack, 0);
        bstop();
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule